// File: doc/BRIEF.md
# Numerically Controlled Oscillator with Loader

This block is the digital core of a direct digital synthesizer. A 32-bit phase accumulator adds a tuning word on every clock. The top 14 bits of the accumulator are offset by a 5-bit phase word. A quarter-wave sine table, mirrored and sign-flipped by quadrant, turns that phase into a signed 10-bit amplitude. The output frequency is tune × f_clk / 2^32, and the frequency resolution is f_clk / 2^32.

The control word is 40 bits wide. It arrives either as five byte writes or as forty single-bit serial writes, and it is collected in a staging buffer. The running oscillator sees none of it until a load strobe arrives with a complete frame. At that point the offset, the sleep flag and the tuning word all change on the same edge. The accumulator is not cleared by a load, so the phase stays continuous.

Top module: `nco_core`

## Requirements
- R1: While rst_n is low, every clock edge sets phase_out and amp_out to 0, and also clears the accumulator, the active control word and the frame count.
- R2: Each clock that is not in sleep adds the active 32-bit tuning word to the accumulator modulo 2^32. phase_out is registered, so it shows accumulator bits [31:18] plus the offset one cycle later.
- R3: The 5-bit offset is added to the 14-bit truncated phase at bits [13:9], modulo 2^14. Offset bit 4 is worth 180° and bit 0 is worth 11.25°.
- R4: amp_out is registered in the same cycle as phase_out. It equals round(511·sin(2π·(phase_out[13:4]+0.5)/1024)) within ±1 and never reaches −512. Phases with bit 13 clear give amplitudes of 0 or more, and phases with bit 13 set give amplitudes of 0 or less.
- R5: A byte write shifts byte_in into the staging buffer, most significant byte first. Frame bits are: [39:35] offset, [34] sleep, [33:32] format (stored, no effect), [31:0] tuning word. So the first byte is {offset, sleep, format} and the next four bytes are the tuning word, high byte first.
- R6: A serial write shifts one bit, ser_din, into the same buffer. Forty serial writes, frame bit 39 first, fill it exactly as five byte writes do. When byte_wr and ser_wr are both high, the byte write wins.
- R7: The active control word changes only on a load_strobe while the frame is complete (40 bits held). It takes effect on the clock after the strobe, and the accumulator is not reset.
- R8: A load_strobe while fewer than 40 bits are held is ignored. Outputs keep following the old word, and the partial frame is kept for completion.
- R9: frame_rst empties the staging count, so partial data is discarded and the next write starts a new frame.
- R10: While the active sleep bit is 1, the accumulator holds its value and amp_out is 0 from the next cycle on.
- R11: Once a frame is complete, further byte or serial writes are ignored until a strobe or frame_rst. A byte write is also refused if it would overflow the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_wr | input | 1 | Byte write enable |
| byte_in | input | 8 | Byte data |
| ser_wr | input | 1 | Serial bit write enable |
| ser_din | input | 1 | Serial data bit |
| frame_rst | input | 1 | Discard staging buffer contents |
| load_strobe | input | 1 | Transfer complete frame to active word |
| phase_out | output | 14 | Registered offset phase |
| amp_out | output | 10 | Registered signed amplitude |

## Verification
The assertions assume that all control inputs are synchronous to clk and that the loader sees single-cycle write pulses it can count. They also assume that nothing outside the loader alters the active word. The stimulus drives every input just after the falling edge and holds it for one full cycle. It always pulses frame_rst, load_strobe and the write enables for exactly one cycle. Deliberate misuse, such as strobes on partial frames and writes past a full frame, stays within those timing rules, so only the frame-completion rules are under test.

// File: rtl/nco_pkg.sv
// Shared sizing defaults for the oscillator and its loader.
// Assumes: the frame is offset + sleep + 2 format bits + tuning word.
package nco_pkg;
    localparam int ACC_W  = 32;   // accumulator width
    localparam int PH_W   = 14;   // truncated phase width
    localparam int OFS_W  = 5;    // phase offset width
    localparam int AMP_W  = 10;   // signed amplitude width
    localparam int TAB_AW = 8;    // quarter table address width
    localparam int BYTE_W = 8;    // byte write width
endpackage

// File: rtl/nco_loader.sv
// Staging buffer plus active control word.
// Byte and serial writes shift into one buffer, most significant first.
// A strobe with a full frame moves offset, sleep and tuning word together.
// Assumes: single-cycle write pulses synchronous to clk.
module nco_loader #(
    parameter int TUNE_W = nco_pkg::ACC_W,
    parameter int OFS_W  = nco_pkg::OFS_W,
    parameter int BYTE_W = nco_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_wr,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              ser_wr,
    input  logic              ser_din,
    input  logic              frame_rst,
    input  logic              load_strobe,
    output logic [TUNE_W-1:0] tune_o,
    output logic [OFS_W-1:0]  ofs_o,
    output logic              pd_o
);
    localparam int FRAME_W = OFS_W + 3 + TUNE_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] ROOM  = CNT_W'(FRAME_W - BYTE_W);
    localparam logic [CNT_W-1:0] BSTEP = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam int PD_BIT  = TUNE_W + 2;

    logic [FRAME_W-1:0] shift_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               full;
    logic               take;

    assign full = (cnt_q == FULL);
    assign take = load_strobe && full;

    // Staging buffer and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (frame_rst || take) begin
            cnt_q   <= '0;
        end else if (byte_wr) begin
            if (cnt_q <= ROOM) begin
                shift_q <= {shift_q[FRAME_W-BYTE_W-1:0], byte_in};
                cnt_q   <= cnt_q + BSTEP;
            end
        end else if (ser_wr && !full) begin
            shift_q <= {shift_q[FRAME_W-2:0], ser_din};
            cnt_q   <= cnt_q + ONE;
        end
    end

    // Active control word, all fields updated on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tune_o <= '0;
            ofs_o  <= '0;
            pd_o   <= 1'b0;
        end else if (take) begin
            tune_o <= shift_q[TUNE_W-1:0];
            ofs_o  <= shift_q[FRAME_W-1 -: OFS_W];
            pd_o   <= shift_q[PD_BIT];
        end
    end

    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
    a_r9_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rst |=> cnt_q == '0);
    a_r8_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strobe && cnt_q != FULL) |=> ($stable(tune_o) && $stable(ofs_o) && $stable(pd_o)));
    a_r7_no_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe |=> ($stable(tune_o) && $stable(ofs_o) && $stable(pd_o)));
endmodule

// File: rtl/nco_phase_acc.sv
// Phase accumulator with hold, truncation and phase offset.
// Assumes: tune and ofs come from registers (stable within a cycle).
module nco_phase_acc #(
    parameter int ACC_W = nco_pkg::ACC_W,
    parameter int PH_W  = nco_pkg::PH_W,
    parameter int OFS_W = nco_pkg::OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] tune,
    input  logic [OFS_W-1:0] ofs,
    input  logic             hold,
    output logic [PH_W-1:0]  phase_o
);
    localparam int PAD = PH_W - OFS_W;

    logic [ACC_W-1:0] acc_q;

    // Accumulate the tuning word unless asleep.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (!hold) acc_q <= acc_q + tune;
    end

    // Truncate and add offset at the top of the phase word.
    assign phase_o = acc_q[ACC_W-1 -: PH_W] + {ofs, {PAD{1'b0}}};

    a_r10_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(acc_q));
    a_r2_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> acc_q == $past(acc_q + tune));
endmodule

// File: rtl/nco_quarter_sine.sv
// Quarter-wave sine lookup with quadrant folding.
// The table is filled at elaboration by an integer Taylor series; entry k
// holds the sine at (k + 0.5) table steps, so mirroring by inversion is exact.
// Assumes: phase carries quadrant in its two top bits.
module nco_quarter_sine #(
    parameter int TAB_AW = nco_pkg::TAB_AW,
    parameter int AMP_W  = nco_pkg::AMP_W
) (
    input  logic [TAB_AW+1:0]       phase,
    output logic signed [AMP_W-1:0] amp
);
    localparam int QD   = 2 ** TAB_AW;
    localparam int AMAX = 2 ** (AMP_W - 1) - 1;

    // Fixed-point sine magnitude for one table entry.
    function automatic logic [AMP_W-2:0] sine_entry(input int k);
        longint pi_q, x, x2, term, s, r;
        pi_q = 64'sd3373259426;
        x    = (longint'(2 * k + 1) * pi_q) / longint'(4 * QD);
        x2   = (x * x) >>> 30;
        term = x;
        s    = x;
        for (int i = 1; i <= 6; i++) begin
            term = -((term * x2) >>> 30) / longint'((2 * i) * (2 * i + 1));
            s    = s + term;
        end
        r = (s * longint'(AMAX) + (64'sd1 <<< 29)) >>> 30;
        return r[AMP_W-2:0];
    endfunction

    logic [AMP_W-2:0]  tab [QD];
    logic [1:0]        quad;
    logic [TAB_AW-1:0] idx;
    logic [AMP_W-2:0]  mag;

    for (genvar k = 0; k < QD; k++) begin : g_tab
        assign tab[k] = sine_entry(k);
    end

    // Fold the phase into the first quadrant and restore the sign.
    always_comb begin
        quad = phase[TAB_AW+1:TAB_AW];
        idx  = quad[0] ? ~phase[TAB_AW-1:0] : phase[TAB_AW-1:0];
        mag  = tab[idx];
        amp  = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
endmodule

// File: rtl/nco_core.sv
// Oscillator top: loader, accumulator, sine table and output registers.
// Phase and amplitude are registered together; sleep forces amplitude to 0.
// Assumes: all inputs synchronous to clk.
module nco_core #(
    parameter int ACC_W  = nco_pkg::ACC_W,
    parameter int PH_W   = nco_pkg::PH_W,
    parameter int OFS_W  = nco_pkg::OFS_W,
    parameter int AMP_W  = nco_pkg::AMP_W,
    parameter int TAB_AW = nco_pkg::TAB_AW,
    parameter int BYTE_W = nco_pkg::BYTE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_wr,
    input  logic [BYTE_W-1:0]       byte_in,
    input  logic                    ser_wr,
    input  logic                    ser_din,
    input  logic                    frame_rst,
    input  logic                    load_strobe,
    output logic [PH_W-1:0]         phase_out,
    output logic signed [AMP_W-1:0] amp_out
);
    logic [ACC_W-1:0]        tune;
    logic [OFS_W-1:0]        ofs;
    logic                    pd;
    logic [PH_W-1:0]         phase_c;
    logic signed [AMP_W-1:0] amp_c;

    nco_loader #(.TUNE_W(ACC_W), .OFS_W(OFS_W), .BYTE_W(BYTE_W)) u_load (
        .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .byte_in(byte_in),
        .ser_wr(ser_wr), .ser_din(ser_din), .frame_rst(frame_rst),
        .load_strobe(load_strobe), .tune_o(tune), .ofs_o(ofs), .pd_o(pd)
    );

    nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W), .OFS_W(OFS_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .tune(tune), .ofs(ofs), .hold(pd),
        .phase_o(phase_c)
    );

    nco_quarter_sine #(.TAB_AW(TAB_AW), .AMP_W(AMP_W)) u_rom (
        .phase(phase_c[PH_W-1 -: TAB_AW+2]), .amp(amp_c)
    );

    // Output registers: phase and amplitude stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_out <= '0;
            amp_out   <= '0;
        end else begin
            phase_out <= phase_c;
            amp_out   <= pd ? '0 : amp_c;
        end
    end

    a_r10_amp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> amp_out == '0);
    a_r4_no_min: assert property (@(posedge clk) disable iff (!rst_n)
        amp_out != {1'b1, {(AMP_W-1){1'b0}}});
    a_r4_upper_sign: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_out[PH_W-1] |-> !amp_out[AMP_W-1]);
    a_r4_lower_sign: assert property (@(posedge clk) disable iff (!rst_n)
        phase_out[PH_W-1] |-> (amp_out[AMP_W-1] || amp_out == '0));
endmodule

// File: tb/sim_nco_core.sv
// Self-checking bench: vector table walked by one loop, then directed cases.
module sim_nco_core;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              byte_wr = 1'b0;
    logic [7:0]        byte_in = '0;
    logic              ser_wr = 1'b0;
    logic              ser_din = 1'b0;
    logic              frame_rst = 1'b0;
    logic              load_strobe = 1'b0;
    logic [13:0]       phase_out;
    logic signed [9:0] amp_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    nco_core u0 (
        .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .byte_in(byte_in),
        .ser_wr(ser_wr), .ser_din(ser_din), .frame_rst(frame_rst),
        .load_strobe(load_strobe), .phase_out(phase_out), .amp_out(amp_out)
    );

    // Requirement model: frame rules (R5-R9, R11), accumulator (R2, R3), sleep (R10).
    int          m_cnt = 0;
    logic [39:0] m_sh = '0;
    logic [31:0] m_tune = '0, m_acc = '0;
    logic [4:0]  m_ofs = '0;
    logic        m_pd = 1'b0, m_zero = 1'b0;
    logic [13:0] m_pw = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_sh <= '0; m_tune <= '0; m_ofs <= '0; m_pd <= 1'b0;
            m_acc <= '0; m_pw <= '0; m_zero <= 1'b0;
        end else begin
            if (frame_rst || (load_strobe && m_cnt == 40)) m_cnt <= 0;
            else if (byte_wr) begin
                if (m_cnt + 8 <= 40) begin m_sh <= {m_sh[31:0], byte_in}; m_cnt <= m_cnt + 8; end
            end else if (ser_wr && m_cnt < 40) begin
                m_sh <= {m_sh[38:0], ser_din}; m_cnt <= m_cnt + 1;
            end
            if (load_strobe && m_cnt == 40) begin
                m_tune <= m_sh[31:0]; m_ofs <= m_sh[39:35]; m_pd <= m_sh[34];
            end
            if (!m_pd) m_acc <= m_acc + m_tune;
            m_pw   <= m_acc[31:18] + {m_ofs, 9'b0};
            m_zero <= m_pd;
        end
    end

    function automatic int sine_ref(input logic [13:0] p);
        real th;
        th = 2.0 * 3.14159265358979 * (real'(p[13:4]) + 0.5) / 1024.0;
        return int'(511.0 * $sin(th));
    endfunction

    task automatic check_out(input string tag);
        int e, d;
        checks++;
        if (phase_out !== m_pw) begin
            errors++;
            $display("FAIL %s phase: actual %0h expected %0h", tag, phase_out, m_pw);
        end
        checks++;
        e = (m_zero || !rst_n) ? 0 : sine_ref(m_pw);
        d = int'(amp_out) - e;
        if (d > 1 || d < -1 || ((m_zero || !rst_n) && d != 0)) begin
            errors++;
            $display("FAIL %s amp: actual %0d expected %0d", tag, amp_out, e);
        end
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic send_bytes(input logic [39:0] f, input string tag);
        for (int b = 4; b >= 0; b--) begin
            byte_wr = 1'b1; byte_in = f[b*8 +: 8];
            tick(tag);
        end
        byte_wr = 1'b0;
    endtask

    task automatic send_serial(input logic [39:0] f, input string tag);
        for (int b = 39; b >= 0; b--) begin
            ser_wr = 1'b1; ser_din = f[b];
            tick(tag);
        end
        ser_wr = 1'b0;
    endtask

    task automatic strobe(input string tag);
        load_strobe = 1'b1;
        tick(tag);
        load_strobe = 1'b0;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    // {offset[4:0], sleep, format[1:0], tune[31:0], cycles[7:0]}
    localparam logic [47:0] VEC [6] = '{
        {5'd0,  1'b0, 2'b00, 32'h0100_0000, 8'd20},
        {5'd16, 1'b0, 2'b01, 32'h0004_0000, 8'd12},
        {5'd3,  1'b0, 2'b10, 32'hFFFC_0000, 8'd12},
        {5'd31, 1'b0, 2'b11, 32'h1234_5678, 8'd16},
        {5'd8,  1'b1, 2'b00, 32'h0800_0000, 8'd8},
        {5'd0,  1'b0, 2'b00, 32'h3000_0001, 8'd16}
    };

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_out("R1 reset");
        rst_n = 1'b1;
        tick("R1 after release");

        // Vector walk: even rows by bytes (R5), odd rows serially (R6).
        for (int i = 0; i < 6; i++) begin
            if (i % 2 == 0) send_bytes(VEC[i][47:8], "R5 byte load");
            else            send_serial(VEC[i][47:8], "R6 serial load");
            strobe("R7 strobe");
            run(int'(VEC[i][7:0]), VEC[i][42] ? "R10 sleep" : "R2/R3/R4 run");
        end

        // R7: staged frame has no effect before the strobe.
        send_bytes({5'd4, 1'b0, 2'b00, 32'h0040_0000}, "R7 staged");
        run(6, "R7 before strobe");
        strobe("R7 transfer");
        run(6, "R7 after strobe");

        // R8: strobe on a partial frame ignored, frame later completed.
        for (int b = 4; b >= 2; b--) begin
            byte_wr = 1'b1; byte_in = 8'h00 | ((b == 4) ? 8'h80 : 8'h02);
            tick("R8 partial");
        end
        byte_wr = 1'b0;
        strobe("R8 ignored strobe");
        run(4, "R8 unchanged");
        byte_wr = 1'b1; byte_in = 8'h00; tick("R8 complete");
        byte_in = 8'h00; tick("R8 complete");
        byte_wr = 1'b0;
        strobe("R8 accepted");
        run(6, "R8 new word");

        // R9: frame reset discards partial bytes.
        byte_wr = 1'b1; byte_in = 8'hFF; tick("R9 partial");
        byte_in = 8'hFF; tick("R9 partial");
        byte_wr = 1'b0;
        frame_rst = 1'b1; tick("R9 frame reset"); frame_rst = 1'b0;
        send_bytes({5'd1, 1'b0, 2'b00, 32'h00C0_0000}, "R9 fresh frame");
        strobe("R9 transfer");
        run(6, "R9 run");

        // R11: writes past a full frame ignored; byte wins over serial (R6).
        send_serial({5'd2, 1'b0, 2'b00, 32'h0200_0000}, "R11 fill");
        byte_wr = 1'b1; byte_in = 8'hAA; tick("R11 extra byte");
        byte_wr = 1'b0;
        ser_wr = 1'b1; ser_din = 1'b1; tick("R11 extra bit");
        ser_wr = 1'b0;
        strobe("R11 transfer");
        run(6, "R11 run");
        frame_rst = 1'b1; tick("R9 clear"); frame_rst = 1'b0;
        byte_wr = 1'b1; ser_wr = 1'b1; ser_din = 1'b1; byte_in = 8'h00;
        tick("R6 precedence");
        byte_wr = 1'b0; ser_wr = 1'b0;
        for (int b = 3; b >= 0; b--) begin
            byte_wr = 1'b1; byte_in = (b == 1) ? 8'h10 : 8'h00;
            tick("R6 precedence fill");
        end
        byte_wr = 1'b0;
        strobe("R6 precedence strobe");
        run(6, "R6 precedence run");

        // R10: sleep frame then wake, accumulator resumes without reset.
        send_bytes({5'd0, 1'b1, 2'b00, 32'h0100_0000}, "R10 sleep load");
        strobe("R10 sleep");
        run(5, "R10 held");
        send_serial({5'd0, 1'b0, 2'b00, 32'h0100_0000}, "R10 wake load");
        strobe("R10 wake");
        run(5, "R10 resumed");

        // R1: reset in mid-run clears outputs.
        rst_n = 1'b0;
        tick("R1 reset again");
        tick("R1 reset held");
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule